// File: doc/BRIEF.md
# Quad Wiper Code and Setting Store Controller

This block sits behind a serial front end that has already turned the bus into whole bytes. It holds four 6-bit wiper codes and, for each wiper, four stored 6-bit settings, sixteen in all. The settings are modelled as a register array that `rst_n` does not clear. Each chip-select frame carries a command byte and, for some commands, a data byte. The commands set or read a wiper, set or read a stored setting, and copy a setting into a wiper or a wiper into a setting. Every wiper code is driven out both as a binary code and as a 64-line one-hot tap select.

Writes to the stored settings are deferred. The write is held pending while chip select stays low and begins only when chip select goes high. A write-protect input blocks these writes and can cancel a pending one. Once a write has begun, the internal write cycle runs for a programmable number of clocks and cannot be stopped. Wiper writes always take effect at once. After reset, each wiper is reloaded from the first stored setting of its own channel.

Top module: `quad_wiper_ctrl`

## Requirements
- R1: One clock after the internal reset is released, wiper w holds stored setting address w*4 (its setting 0), with no bus activity.
- R2: The command byte is the first byte of a frame. Bits 7:4 are the opcode, bits 3:2 the wiper index w, and bits 1:0 the setting index d, so the setting address is w*4+d. The opcodes are: 1 set wiper, 2 read wiper, 3 set stored setting, 4 read stored setting, 5 copy setting to wiper, 6 copy wiper to setting. Any other opcode changes no wiper, no setting and no output.
- R3: For opcode 1, bits 5:0 of the second byte appear on wiper w one clock after that byte, whatever the level of `wp_n`.
- R4: Opcodes 2 and 4 pulse `rd_valid` for one clock, one clock after the command byte. `rd_data` then holds wiper w or setting w*4+d.
- R5: An opcode 3 write is taken with its second byte, but the setting does not change while `cs_n` stays low. `busy` rises one clock after `cs_n` goes high and stays high for exactly WRITE_CYCLES clocks. The setting holds the new value once `busy` falls.
- R6: A setting write is not taken if `wp_n` is low when its final byte arrives. If `wp_n` goes low at any time while `cs_n` is still low, a write that has already been taken is cancelled and `busy` never rises.
- R7: Once `busy` has risen, changes on `wp_n` do not stop the write.
- R8: While `busy` is high, opcodes 3 and 6 are ignored and do not restart the cycle. Wiper commands still act.
- R9: Any further byte in the same frame after the byte that completed a setting write cancels that write.
- R10: Opcode 5 loads setting w*4+d into wiper w one clock after the command byte. Opcode 6 stores wiper w into setting w*4+d under the deferred rules of R5, R6 and R9.
- R11: `standby` is high exactly when `cs_n` is high and `busy` is low.
- R12: For each wiper w, `tap_sel[w*64 +: 64]` has exactly one bit set, at the bit position equal to the wiper code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the front end, active low |
| wp_n | input | 1 | Write protect for stored settings, active low |
| byte_valid | input | 1 | A received byte is present on byte_data |
| byte_data | input | 8 | Received byte |
| rd_valid | output | 1 | One-clock strobe for read results |
| rd_data | output | 6 | Read result |
| busy | output | 1 | Internal setting write cycle in progress |
| standby | output | 1 | Deselected and idle |
| wiper_code | output | 24 | Four 6-bit wiper codes, wiper 0 in the low bits |
| tap_sel | output | 256 | Four 64-bit one-hot tap selects, wiper 0 in the low bits |

## Verification
The hardest situations to reach are timing races around the deferred write. One is a `wp_n` drop that lands after a write was taken but before `cs_n` rises. Another is a `wp_n` drop, or a new write attempt, that lands inside the busy window. A third is an extra byte that turns a complete sequence into an invalid one. Directed frames create each race by toggling `wp_n` or adding bytes at chosen clocks. A read frame afterwards shows whether the stored setting changed. Seeded random frames of wiper, copy and read commands then run against a bench model of all twenty registers. A second reset checks the recall against the stored values the bench has written.

// File: rtl/qwc_pkg.sv
package qwc_pkg;
  localparam int WSEL_W = 2;
  localparam int DSEL_W = 2;
  localparam int NUM_WIPERS = 1 << WSEL_W;
  localparam int NUM_SET = 1 << DSEL_W;
  localparam int ADDR_W = WSEL_W + DSEL_W;
  localparam int NUM_STORE = NUM_WIPERS * NUM_SET;

  localparam logic [3:0] OP_SET_WIPER = 4'h1;
  localparam logic [3:0] OP_GET_WIPER = 4'h2;
  localparam logic [3:0] OP_SET_STORE = 4'h3;
  localparam logic [3:0] OP_GET_STORE = 4'h4;
  localparam logic [3:0] OP_LOAD      = 4'h5;
  localparam logic [3:0] OP_SAVE      = 4'h6;

  typedef struct packed {
    logic [3:0]        op;
    logic [WSEL_W-1:0] wsel;
    logic [DSEL_W-1:0] dsel;
  } qwc_cmd_t;
endpackage

// File: rtl/qwc_frame.sv
module qwc_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic byte_valid,
  output logic is_cmd,
  output logic is_data,
  output logic in_frame,
  output logic cs_rise
);
  logic [1:0] cnt_q, cnt_d;
  logic       cs_q;

  always_comb begin
    cnt_d = cnt_q;
    if (cs_n) cnt_d = 2'd0;
    else if (byte_valid && cnt_q != 2'd2) cnt_d = cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      cs_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      cs_q  <= cs_n;
    end
  end

  assign in_frame = byte_valid & ~cs_n;
  assign is_cmd   = in_frame & (cnt_q == 2'd0);
  assign is_data  = in_frame & (cnt_q == 2'd1);
  assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/qwc_nvwrite.sv
module qwc_nvwrite #(
  parameter int CODE_W = 6,
  parameter int ADDR_W = 4,
  parameter int WRITE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              cs_rise,
  input  logic              in_frame,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CODE_W-1:0] req_val,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CODE_W-1:0] mem_wdata
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q;
  logic [CODE_W-1:0] val_q;
  logic              take;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d;

  assign busy = (wcnt_q != '0);
  assign take = req & wp_n & ~busy;

  always_comb begin
    pend_d = pend_q;
    if (cs_rise) pend_d = 1'b0;
    else if (!cs_n && !wp_n) pend_d = 1'b0;
    else if (in_frame && pend_q) pend_d = 1'b0;
    else if (take) pend_d = 1'b1;
  end

  always_comb begin
    wcnt_d = wcnt_q;
    if (cs_rise && pend_q) wcnt_d = CNT_W'(WRITE_CYCLES);
    else if (busy) wcnt_d = wcnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wcnt_q <= '0;
    end else begin
      pend_q <= pend_d;
      wcnt_q <= wcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      val_q  <= '0;
    end else if (take && !pend_q) begin
      addr_q <= req_addr;
      val_q  <= req_val;
    end
  end

  assign mem_we    = (wcnt_q == CNT_W'(1));
  assign mem_addr  = addr_q;
  assign mem_wdata = val_q;

  // R8
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !pend_q);
  // R6
  wp_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && !wp_n) |=> !pend_q);
  // R9
  extra_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n) (pend_q && in_frame) |=> !pend_q);
  // R5
  start_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cs_n) && $past(pend_q)));
endmodule

// File: rtl/qwc_tapdec.sv
module qwc_tapdec #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0]        code,
  output logic [(1<<CODE_W)-1:0]   taps
);
  always_comb begin
    taps = '0;
    taps[code] = 1'b1;
  end
endmodule

// File: rtl/quad_wiper_ctrl.sv
module quad_wiper_ctrl
  import qwc_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int WRITE_CYCLES = 40
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cs_n,
  input  logic                               wp_n,
  input  logic                               byte_valid,
  input  logic [7:0]                         byte_data,
  output logic                               rd_valid,
  output logic [CODE_W-1:0]                  rd_data,
  output logic                               busy,
  output logic                               standby,
  output logic [NUM_WIPERS*CODE_W-1:0]       wiper_code,
  output logic [NUM_WIPERS*(1<<CODE_W)-1:0]  tap_sel
);
  localparam int TAPS = 1 << CODE_W;

  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic is_cmd, is_data, in_frame, cs_rise;

  qwc_frame i_frame (
    .clk(clk), .rst_n(rst_s_n), .cs_n(cs_n), .byte_valid(byte_valid),
    .is_cmd(is_cmd), .is_data(is_data), .in_frame(in_frame), .cs_rise(cs_rise)
  );

  qwc_cmd_t          cmd_q, cur;
  logic              rcl_q;
  logic [CODE_W-1:0] wiper_q [NUM_WIPERS];
  logic [CODE_W-1:0] wiper_d [NUM_WIPERS];
  logic [CODE_W-1:0] store   [NUM_STORE];
  logic [ADDR_W-1:0] cur_addr;
  logic              act_cmd, act_data;
  logic              rd_valid_d;
  logic [CODE_W-1:0] rd_data_d;
  logic              nv_req;
  logic [CODE_W-1:0] nv_val;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [CODE_W-1:0] mem_wdata;

  assign act_cmd  = is_cmd & ~rcl_q;
  assign act_data = is_data & ~rcl_q;
  assign cur      = is_cmd ? qwc_cmd_t'(byte_data) : cmd_q;
  assign cur_addr = {cur.wsel, cur.dsel};

  always_comb begin
    for (int i = 0; i < NUM_WIPERS; i++) wiper_d[i] = wiper_q[i];
    if (rcl_q) begin
      for (int i = 0; i < NUM_WIPERS; i++) wiper_d[i] = store[i*NUM_SET];
    end else if (act_data && cmd_q.op == OP_SET_WIPER) begin
      wiper_d[cmd_q.wsel] = byte_data[CODE_W-1:0];
    end else if (act_cmd && cur.op == OP_LOAD) begin
      wiper_d[cur.wsel] = store[cur_addr];
    end
  end

  always_comb begin
    rd_valid_d = act_cmd & ((cur.op == OP_GET_WIPER) | (cur.op == OP_GET_STORE));
    rd_data_d  = (cur.op == OP_GET_WIPER) ? wiper_q[cur.wsel] : store[cur_addr];
  end

  always_comb begin
    nv_req = 1'b0;
    nv_val = byte_data[CODE_W-1:0];
    if (act_data && cmd_q.op == OP_SET_STORE) begin
      nv_req = 1'b1;
    end else if (act_cmd && cur.op == OP_SAVE) begin
      nv_req = 1'b1;
      nv_val = wiper_q[cur.wsel];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rcl_q    <= 1'b1;
      rd_valid <= 1'b0;
      for (int i = 0; i < NUM_WIPERS; i++) wiper_q[i] <= '0;
    end else begin
      rcl_q    <= 1'b0;
      rd_valid <= rd_valid_d;
      for (int i = 0; i < NUM_WIPERS; i++) wiper_q[i] <= wiper_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rd_data <= '0;
    end else if (rd_valid_d) begin
      rd_data <= rd_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cmd_q <= '0;
    end else if (is_cmd) begin
      cmd_q <= qwc_cmd_t'(byte_data);
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) store[mem_addr] <= mem_wdata;
  end

  qwc_nvwrite #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) i_nvwrite (
    .clk(clk), .rst_n(rst_s_n), .cs_n(cs_n), .wp_n(wp_n), .cs_rise(cs_rise),
    .in_frame(in_frame), .req(nv_req), .req_addr(cur_addr), .req_val(nv_val),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign standby = cs_n & ~busy;

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_wiper
    assign wiper_code[g*CODE_W +: CODE_W] = wiper_q[g];

    qwc_tapdec #(.CODE_W(CODE_W)) i_tapdec (
      .code(wiper_q[g]),
      .taps(tap_sel[g*TAPS +: TAPS])
    );

    // R12
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      $onehot(tap_sel[g*TAPS +: TAPS]) && tap_sel[g*TAPS + int'(wiper_code[g*CODE_W +: CODE_W])]);
    // R1
    recall_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      rcl_q |=> wiper_q[g] == $past(store[g*NUM_SET]));
    // R3
    wr_wiper_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      (act_data && cmd_q.op == OP_SET_WIPER && cmd_q.wsel == WSEL_W'(g))
      |=> wiper_code[g*CODE_W +: CODE_W] == $past(byte_data[CODE_W-1:0]));
  end

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n) rd_valid |=> !rd_valid);
endmodule

// File: tb/test_quad_wiper_ctrl.sv
module test_quad_wiper_ctrl;
  localparam int WC = 40;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cs_n, wp_n, byte_valid;
  logic [7:0]   byte_data;
  logic         rd_valid, busy, standby;
  logic [5:0]   rd_data;
  logic [23:0]  wiper_code;
  logic [255:0] tap_sel;

  int checks = 0;
  int fails  = 0;
  logic [5:0] wm [4];
  logic [5:0] dm [16];

  always #4 clk = ~clk;

  quad_wiper_ctrl #(.CODE_W(6), .WRITE_CYCLES(WC)) i_quad_wiper_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .byte_valid(byte_valid),
    .byte_data(byte_data), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .standby(standby), .wiper_code(wiper_code), .tap_sel(tap_sel)
  );

  function automatic logic [7:0] mk(input logic [3:0] op, input int w, input int d);
    return {op, 2'(w), 2'(d)};
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cs_lo();
    @(negedge clk) cs_n = 1'b0;
  endtask

  task automatic cs_hi();
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin byte_valid = 1'b1; byte_data = b; end
    @(negedge clk) byte_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic check_wipers(input string tag);
    for (int w = 0; w < 4; w++) begin
      chk(int'(wiper_code[w*6 +: 6]), int'(wm[w]), tag);
      chk(int'(tap_sel[w*64 +: 64] == (64'd1 << wm[w])), 1, {tag, " R12 tap"});
    end
  endtask

  task automatic store_write(input int w, input int d, input logic [5:0] v);
    int n;
    cs_lo(); send(mk(4'h3, w, d)); send({2'b00, v}); cs_hi();
    wait_idle(n);
  endtask

  task automatic read_store(input int w, input int d, input string tag);
    cs_lo(); send(mk(4'h4, w, d));
    chk(int'(rd_valid), 1, {tag, " R4 valid"});
    chk(int'(rd_data), int'(dm[w*4+d]), tag);
    cs_hi();
  endtask

  task automatic read_wiper(input int w, input string tag);
    cs_lo(); send(mk(4'h2, w, 0));
    chk(int'(rd_valid), 1, {tag, " R4 valid"});
    chk(int'(rd_data), int'(wm[w]), tag);
    @(negedge clk);
    chk(int'(rd_valid), 0, {tag, " R4 pulse"});
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int seed;
    cs_n = 1'b1; wp_n = 1'b1; byte_valid = 1'b0; byte_data = '0; rst_n = 1'b0;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(int'(busy), 0, "reset busy R5");
    chk(int'(standby), 1, "reset standby R11");
    chk(int'(rd_valid), 0, "reset rd_valid R4");

    // R5: fill all stored settings, check busy length on the first
    for (int a = 0; a < 16; a++) begin
      dm[a] = 6'($urandom);
      cs_lo(); send(mk(4'h3, a/4, a%4)); send({2'b00, dm[a]});
      if (a == 0) begin
        chk(int'(busy), 0, "R5 no busy while cs low");
        chk(int'(standby), 0, "R11 selected");
      end
      cs_hi();
      chk(int'(busy), 1, "R5 busy after cs rise");
      chk(int'(standby), 0, "R11 busy not standby");
      wait_idle(n);
      if (a == 0) chk(n, WC, "R5 busy length");
      chk(int'(standby), 1, "R11 idle standby");
    end
    for (int a = 0; a < 16; a++) read_store(a/4, a%4, "R5 readback");

    // R1: recall on reset
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int w = 0; w < 4; w++) wm[w] = dm[w*4];
    check_wipers("R1 recall");

    // R3: wiper write with write protect low
    wp_n = 1'b0;
    cs_lo(); send(mk(4'h1, 2, 3)); send(8'hE5);
    wm[2] = 6'h25;
    check_wipers("R3 wiper write wp low");
    cs_hi();
    // R6: store write with write protect low is blocked
    cs_lo(); send(mk(4'h3, 1, 2)); send(8'h3F); cs_hi();
    chk(int'(busy), 0, "R6 blocked no busy");
    wp_n = 1'b1;
    read_store(1, 2, "R6 blocked unchanged");

    // R6: wp drop while cs low cancels a taken write
    cs_lo(); send(mk(4'h3, 3, 1)); send(8'h2A);
    @(negedge clk) wp_n = 1'b0;
    @(negedge clk) wp_n = 1'b1;
    cs_hi();
    chk(int'(busy), 0, "R6 cancel no busy");
    read_store(3, 1, "R6 cancel unchanged");

    // R7: wp drop during busy does not stop the write; R8: ignored while busy
    cs_lo(); send(mk(4'h3, 0, 3)); send(8'h11); cs_hi();
    wp_n = 1'b0;
    chk(int'(busy), 1, "R7 started");
    @(negedge clk) wp_n = 1'b1;
    cs_lo(); send(mk(4'h3, 0, 2)); send(8'h07); cs_hi();
    cs_lo(); send(mk(4'h1, 1, 0)); send(8'h09); cs_hi();
    wm[1] = 6'h09;
    check_wipers("R8 wiper acts while busy");
    dm[3] = 6'h11;
    wait_idle(n);
    chk(n < WC ? 1 : 0, 1, "R8 no restart");
    @(negedge clk);
    chk(int'(busy), 0, "R8 no second cycle");
    read_store(0, 3, "R7 committed");
    read_store(0, 2, "R8 ignored while busy");

    // R9: extra byte cancels
    cs_lo(); send(mk(4'h3, 2, 2)); send(8'h15); send(8'h00); cs_hi();
    chk(int'(busy), 0, "R9 extra byte no busy");
    read_store(2, 2, "R9 unchanged");
    cs_lo(); send(mk(4'h6, 2, 2)); send(8'h00); cs_hi();
    chk(int'(busy), 0, "R9 save extra byte");

    // R10: save and load
    cs_lo(); send(mk(4'h6, 2, 1)); cs_hi();
    chk(int'(busy), 1, "R10 save busy");
    wait_idle(n);
    dm[9] = wm[2];
    read_store(2, 1, "R10 save");
    cs_lo(); send(mk(4'h5, 0, 1));
    wm[0] = dm[1];
    check_wipers("R10 load");
    cs_hi();

    // R2: unknown opcodes have no effect
    cs_lo(); send(8'hF5); send(8'h3F);
    chk(int'(rd_valid), 0, "R2 unknown no read");
    cs_hi();
    chk(int'(busy), 0, "R2 unknown no busy");
    cs_lo(); send(8'h05); send(8'h00); cs_hi();
    check_wipers("R2 unknown wipers");
    read_store(1, 1, "R2 unknown store");

    // Random mix of wiper, load and read commands
    for (int i = 0; i < 200; i++) begin
      int kind = int'($urandom_range(0, 3));
      int w = int'($urandom_range(0, 3));
      int d = int'($urandom_range(0, 3));
      logic [5:0] v = 6'($urandom);
      wp_n = 1'($urandom);
      case (kind)
        0: begin cs_lo(); send(mk(4'h1, w, d)); send({2'($urandom), v}); cs_hi(); wm[w] = v; end
        1: begin cs_lo(); send(mk(4'h5, w, d)); cs_hi(); wm[w] = dm[w*4+d]; end
        2: read_wiper(w, "R4 random wiper");
        default: read_store(w, d, "R4 random store");
      endcase
      check_wipers("R3 random wipers");
    end
    wp_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule